// File: doc/BRIEF.md
# Remote DMA Command Controller

This block is the command front end of a local-bus network controller. The host writes an 8-bit command register and a small set of byte-wide setup registers. From these it selects a register page, starts or stops the controller, requests a packet transmission and runs a byte-serial transfer between a host data port and an internal packet buffer. The transfer runs in one of two directions: toward the host (read) or into the buffer (write).

To run a transfer, the host programs a 16-bit start address and a 16-bit byte count while the engine is idle. It then issues a read or write code in the three-bit transfer field (bits 5:3) of the command register. Each strobe on the data port then moves one byte at the current address, advances that address and lowers the remaining count. When the count runs out, the engine goes idle and reports the idle code in the field. It also sends a one-cycle completion pulse to the interrupt logic.

The host can abort a transfer at any time by writing any code with bit 5 set. An abort clears the remaining count and leaves the current address where it stopped.

Top module: `rdma_cmd_ctrl`

## Requirements
- R1: After synchronous reset, `page_sel` is 00, `running`, `dma_busy`, `dma_done` and `tx_req` are 0, the command register reads 0x21 (page 00, field 100, bit 1 = 0, bit 0 = 1), and the count and address registers read 0.
- R2: Command bits 7:6 are stored and driven on `page_sel`. Offsets 1 to 6 belong to page 00 only. On any other page, writes to them are ignored and reads of them return 0.
- R3: Command bit 1 sets `running` and bit 0 clears it; bit 0 wins when both are set. Bit 2 gives a one-cycle `tx_req` in the cycle after the write. Reads return `running` in bit 1, its inverse in bit 0, and 0 in bit 2.
- R4: Writing field code 001 (read) or 010 (write) while idle loads the current address from the start address and raises `dma_busy` in the next cycle. While busy, the field reads back that code.
- R5: Field codes 000 and 011 start nothing. A read or write code written while busy is ignored, and the running transfer continues unchanged.
- R6: While busy, each `dp_strobe` makes exactly one buffer access at the current address, then adds 1 to the address and subtracts 1 from the count. A read access asserts `mem_re` and returns `mem_rdata` on `dp_rdata`. A write access asserts `mem_we` with `mem_wdata` = `dp_wdata`. A strobe while idle makes no access and changes no register.
- R7: A strobe that consumes the last byte makes `dma_busy` 0 and `dma_done` 1 for exactly one cycle, both in the next cycle, and the field reads 100. A read or write code issued with a count of 0 gives the `dma_done` pulse in the next cycle without ever becoming busy.
- R8: Writing a command with bit 5 set while busy ends the transfer in the next cycle: the count becomes 0, the current address keeps its value, and no `dma_done` pulse is given. A strobe in the same cycle as the abort makes no access. An abort code written while idle changes neither the count nor the address.
- R9: The setup map is: offset 1 start address low byte, offset 2 start address high byte, offset 3 count low byte, offset 4 count high byte, offsets 5 and 6 current address low and high byte (read-only). Offsets 3 and 4 read back the remaining count. Start and count writes take effect only while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| dp_strobe | input | 1 | Host data-port access strobe |
| dp_wdata | input | 8 | Data-port byte from host |
| dp_rdata | output | 8 | Data-port byte to host |
| mem_addr | output | 16 | Buffer address (current address) |
| mem_re | output | 1 | Buffer read enable |
| mem_we | output | 1 | Buffer write enable |
| mem_wdata | output | 8 | Buffer write data |
| mem_rdata | input | 8 | Buffer read data |
| page_sel | output | 2 | Selected register page |
| running | output | 1 | Controller started |
| tx_req | output | 1 | One-cycle transmit request |
| dma_done | output | 1 | One-cycle transfer completion pulse |
| dma_busy | output | 1 | Transfer in progress |

## Verification
A host abort and a data-port strobe can land in the same cycle. The abort must win: that strobe makes no buffer access and does not move the address. The bench provokes this on purpose with a directed case, raising the abort write and the strobe together on one edge during a running transfer. Random trials also place aborts at chosen bytes. The bench judges the case at the ports in three ways: the enables during that cycle, the absence of a completion pulse, and the count and current address read back afterwards, compared with a model position that stopped at the last accepted byte.

// File: rtl/rdma_pkg.sv
package rdma_pkg;
    localparam int BYTE_W     = 8;
    localparam int ADDR_W     = 16;
    localparam int CNT_W      = 16;
    localparam int REG_AW     = 3;
    localparam int ADDR_BYTES = ADDR_W / BYTE_W;

    typedef enum logic [REG_AW-1:0] {
        RG_CMD   = 3'd0,
        RG_SA_LO = 3'd1,
        RG_SA_HI = 3'd2,
        RG_BC_LO = 3'd3,
        RG_BC_HI = 3'd4,
        RG_CA_LO = 3'd5,
        RG_CA_HI = 3'd6,
        RG_RSV   = 3'd7
    } reg_sel_e;

    typedef enum logic [1:0] {
        DIR_NONE = 2'd0,
        DIR_RD   = 2'd1,
        DIR_WR   = 2'd2
    } dma_dir_e;

    typedef struct packed {
        logic [1:0] page;
        logic       abort;
        dma_dir_e   go;
        logic       txp;
        logic       start;
        logic       stop;
    } cmd_t;

    function automatic cmd_t decode_cmd(input logic [BYTE_W-1:0] b);
        cmd_t c;
        c.page  = b[7:6];
        c.abort = b[5];
        if (b[5])                c.go = DIR_NONE;
        else if (b[4:3] == 2'b01) c.go = DIR_RD;
        else if (b[4:3] == 2'b10) c.go = DIR_WR;
        else                     c.go = DIR_NONE;
        c.txp   = b[2];
        c.start = b[1];
        c.stop  = b[0];
        return c;
    endfunction

    function automatic logic [2:0] field_code(input logic busy, input dma_dir_e dir);
        if (!busy)              return 3'b100;
        else if (dir == DIR_RD) return 3'b001;
        else                    return 3'b010;
    endfunction
endpackage

// File: rtl/rdma_cmd_dec.sv
module rdma_cmd_dec
    import rdma_pkg::*;
(
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [BYTE_W-1:0] reg_wdata,
    input  logic [1:0]        page,
    output logic              cmd_wr,
    output cmd_t              cmd,
    output logic [1:0]        sa_we,
    output logic [1:0]        bc_we
);
    logic page0;
    reg_sel_e sel;

    always_comb begin
        sel    = reg_sel_e'(reg_addr);
        page0  = (page == 2'b00);
        cmd    = decode_cmd(reg_wdata);
        cmd_wr = reg_wr && (sel == RG_CMD);
        sa_we  = {reg_wr && page0 && (sel == RG_SA_HI), reg_wr && page0 && (sel == RG_SA_LO)};
        bc_we  = {reg_wr && page0 && (sel == RG_BC_HI), reg_wr && page0 && (sel == RG_BC_LO)};
    end
endmodule

// File: rtl/rdma_engine.sv
module rdma_engine
    import rdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_wr,
    input  logic              cmd_abort,
    input  dma_dir_e          cmd_go,
    input  logic [1:0]        sa_we,
    input  logic [1:0]        bc_we,
    input  logic [BYTE_W-1:0] wbyte,
    input  logic              dp_strobe,
    output logic              busy,
    output dma_dir_e          dir,
    output logic [ADDR_W-1:0] start_addr,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [CNT_W-1:0]  count,
    output logic              xfer_rd,
    output logic              xfer_wr,
    output logic              done
);
    logic abort_now, launch, step;

    assign abort_now = cmd_wr && cmd_abort;
    assign launch    = cmd_wr && !cmd_abort && (cmd_go != DIR_NONE) && !busy;
    assign step      = dp_strobe && busy && !abort_now;
    assign xfer_rd   = step && (dir == DIR_RD);
    assign xfer_wr   = step && (dir == DIR_WR);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy       <= 1'b0;
            dir        <= DIR_NONE;
            start_addr <= '0;
            cur_addr   <= '0;
            count      <= '0;
            done       <= 1'b0;
        end else begin
            done <= 1'b0;
            if (abort_now) begin
                if (busy) begin
                    busy  <= 1'b0;
                    dir   <= DIR_NONE;
                    count <= '0;
                end
            end else if (launch) begin
                cur_addr <= start_addr;
                if (count == '0) begin
                    done <= 1'b1;
                end else begin
                    busy <= 1'b1;
                    dir  <= cmd_go;
                end
            end else if (step) begin
                cur_addr <= cur_addr + 1'b1;
                count    <= count - 1'b1;
                if (count == CNT_W'(1)) begin
                    busy <= 1'b0;
                    dir  <= DIR_NONE;
                    done <= 1'b1;
                end
            end
            if (!busy) begin
                for (int i = 0; i < ADDR_BYTES; i++) begin
                    if (sa_we[i]) start_addr[i*BYTE_W +: BYTE_W] <= wbyte;
                    if (bc_we[i]) count[i*BYTE_W +: BYTE_W]      <= wbyte;
                end
            end
        end
    end

    // R6: an accepted byte moves the address up and the count down by one
    p_advance_r6: assert property (@(posedge clk) disable iff (rst)
        (step && count > CNT_W'(1)) |=> (cur_addr == $past(cur_addr) + 1'b1) && (count == $past(count) - 1'b1));

    // R8: abort clears the count but freezes the address
    p_abort_keeps_addr_r8: assert property (@(posedge clk) disable iff (rst)
        (abort_now && busy) |=> (!busy && count == '0 && cur_addr == $past(cur_addr) && !done));

    // R7: completion pulse only while idle
    p_done_idle_r7: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R7: a busy engine always has bytes left
    p_busy_count_r7: assert property (@(posedge clk) disable iff (rst)
        busy |-> (count != '0));

    // R9: start address frozen while a transfer runs
    p_hold_prog_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && sa_we != 2'b00) |=> $stable(start_addr));
endmodule

// File: rtl/rdma_readback.sv
module rdma_readback
    import rdma_pkg::*;
(
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [1:0]        page,
    input  logic              run,
    input  logic              busy,
    input  dma_dir_e          dir,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [CNT_W-1:0]  count,
    output logic [BYTE_W-1:0] rdata
);
    always_comb begin
        rdata = '0;
        case (reg_sel_e'(reg_addr))
            RG_CMD:   rdata = {page, field_code(busy, dir), 1'b0, run, ~run};
            RG_SA_LO: rdata = start_addr[BYTE_W-1:0];
            RG_SA_HI: rdata = start_addr[2*BYTE_W-1:BYTE_W];
            RG_BC_LO: rdata = count[BYTE_W-1:0];
            RG_BC_HI: rdata = count[2*BYTE_W-1:BYTE_W];
            RG_CA_LO: rdata = cur_addr[BYTE_W-1:0];
            RG_CA_HI: rdata = cur_addr[2*BYTE_W-1:BYTE_W];
            default:  rdata = '0;
        endcase
        if (reg_sel_e'(reg_addr) != RG_CMD && page != 2'b00) rdata = '0;
    end
endmodule

// File: rtl/rdma_cmd_ctrl.sv
module rdma_cmd_ctrl
    import rdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    input  logic              dp_strobe,
    input  logic [BYTE_W-1:0] dp_wdata,
    output logic [BYTE_W-1:0] dp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_re,
    output logic              mem_we,
    output logic [BYTE_W-1:0] mem_wdata,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic [1:0]        page_sel,
    output logic              running,
    output logic              tx_req,
    output logic              dma_done,
    output logic              dma_busy
);
    logic              cmd_wr;
    cmd_t              cmd;
    logic [1:0]        sa_we, bc_we;
    dma_dir_e          dir;
    logic [ADDR_W-1:0] start_addr, cur_addr;
    logic [CNT_W-1:0]  count;
    logic              xfer_rd, xfer_wr;

    rdma_cmd_dec u_dec (
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .page      (page_sel),
        .cmd_wr    (cmd_wr),
        .cmd       (cmd),
        .sa_we     (sa_we),
        .bc_we     (bc_we)
    );

    rdma_engine u_eng (
        .clk        (clk),
        .rst        (rst),
        .cmd_wr     (cmd_wr),
        .cmd_abort  (cmd.abort),
        .cmd_go     (cmd.go),
        .sa_we      (sa_we),
        .bc_we      (bc_we),
        .wbyte      (reg_wdata),
        .dp_strobe  (dp_strobe),
        .busy       (dma_busy),
        .dir        (dir),
        .start_addr (start_addr),
        .cur_addr   (cur_addr),
        .count      (count),
        .xfer_rd    (xfer_rd),
        .xfer_wr    (xfer_wr),
        .done       (dma_done)
    );

    rdma_readback u_rb (
        .reg_addr   (reg_addr),
        .page       (page_sel),
        .run        (running),
        .busy       (dma_busy),
        .dir        (dir),
        .start_addr (start_addr),
        .cur_addr   (cur_addr),
        .count      (count),
        .rdata      (reg_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            page_sel <= 2'b00;
            running  <= 1'b0;
            tx_req   <= 1'b0;
        end else begin
            tx_req <= cmd_wr && cmd.txp;
            if (cmd_wr) begin
                page_sel <= cmd.page;
                if (cmd.stop)       running <= 1'b0;
                else if (cmd.start) running <= 1'b1;
            end
        end
    end

    assign mem_addr  = cur_addr;
    assign mem_re    = xfer_rd;
    assign mem_we    = xfer_wr;
    assign mem_wdata = dp_wdata;
    assign dp_rdata  = xfer_rd ? mem_rdata : '0;

    // R6: never a read and a write in one cycle
    p_single_access_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_re, mem_we}));

    // R3: stop has priority over start
    p_stop_wins_r3: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && cmd.stop) |=> !running);

    // R7: idle engine reports the idle field code
    p_idle_field_r7: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == 3'd0 && !dma_busy) |-> (reg_rdata[5:3] == 3'b100));
endmodule

// File: tb/tb_rdma_cmd_ctrl.sv
`timescale 1ns/1ps
module tb_rdma_cmd_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       dp_strobe = 1'b0;
    logic [7:0] dp_wdata = '0;
    logic [7:0] dp_rdata;
    logic [15:0] mem_addr;
    logic       mem_re, mem_we;
    logic [7:0] mem_wdata, mem_rdata;
    logic [1:0] page_sel;
    logic       running, tx_req, dma_done, dma_busy;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    function automatic logic [7:0] mem_model(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hC3;
    endfunction

    function automatic logic [7:0] exp_cmd(input logic [1:0] pg, input logic [2:0] fld, input logic run);
        return {pg, fld, 1'b0, run, ~run};
    endfunction

    assign mem_rdata = mem_model(mem_addr);

    rdma_cmd_ctrl dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic program_xfer(input logic [15:0] sa, input logic [15:0] cnt);
        wr(3'd1, sa[7:0]);  wr(3'd2, sa[15:8]);
        wr(3'd3, cnt[7:0]); wr(3'd4, cnt[15:8]);
    endtask

    task automatic strobe(input logic [7:0] wd, output logic re, output logic we,
                          output logic [15:0] a, output logic [7:0] rdat, output logic [7:0] wdat);
        @(negedge clk);
        dp_strobe = 1'b1; dp_wdata = wd;
        #1;
        re = mem_re; we = mem_we; a = mem_addr; rdat = dp_rdata; wdat = mem_wdata;
        @(negedge clk);
        dp_strobe = 1'b0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog all-requirements actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] d, rdat, wdat;
        logic re, we;
        logic [15:0] a, exp_a;
        logic [15:0] sa, cnt;
        void'($urandom(32'd1957));

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(3'd0, d); chk("R1 cmd", d, 8'h21);
        chk("R1 page", page_sel, 2'b00);
        chk("R1 run/busy/done/tx", {running, dma_busy, dma_done, tx_req}, 4'b0000);
        rd(3'd3, d); chk("R1 count", d, 8'h00);
        rd(3'd5, d); chk("R1 addr", d, 8'h00);

        // R3 start, transmit request, stop priority
        wr(3'd0, 8'h22);
        chk("R3 running", running, 1'b1);
        rd(3'd0, d); chk("R3 readback", d, exp_cmd(2'b00, 3'b100, 1'b1));
        wr(3'd0, 8'h26);
        chk("R3 tx_req pulse", tx_req, 1'b1);
        @(negedge clk); chk("R3 tx_req single", tx_req, 1'b0);
        rd(3'd0, d); chk("R3 bit2 reads 0", d[2], 1'b0);
        wr(3'd0, 8'h23);
        chk("R3 stop wins", running, 1'b0);
        wr(3'd0, 8'h22);

        // R2 page select and page-0 register gating
        wr(3'd1, 8'h34);
        wr(3'd0, 8'h62);
        chk("R2 page_sel", page_sel, 2'b01);
        wr(3'd1, 8'hAA);
        rd(3'd1, d); chk("R2 read on page1", d, 8'h00);
        wr(3'd0, 8'h22);
        rd(3'd1, d); chk("R2 write ignored on page1", d, 8'h34);

        // R4 R6 R7 read transfer
        program_xfer(16'h1234, 16'd3);
        wr(3'd0, 8'h0A);
        chk("R4 busy", dma_busy, 1'b1);
        rd(3'd0, d); chk("R4 field read", d[5:3], 3'b001);
        rd(3'd5, d); chk("R4 addr lo", d, 8'h34);
        rd(3'd6, d); chk("R4 addr hi", d, 8'h12);
        for (int i = 0; i < 3; i++) begin
            strobe(8'h00, re, we, a, rdat, wdat);
            chk("R6 read enables", {re, we}, 2'b10);
            chk("R6 read addr", a, 16'h1234 + i);
            chk("R6 read data", rdat, mem_model(16'h1234 + i));
        end
        chk("R7 done pulse", dma_done, 1'b1);
        chk("R7 idle", dma_busy, 1'b0);
        @(negedge clk); chk("R7 done single", dma_done, 1'b0);
        rd(3'd0, d); chk("R7 field idle", d[5:3], 3'b100);
        rd(3'd3, d); chk("R9 count readback", d, 8'h00);
        rd(3'd5, d); chk("R6 final addr", d, 8'h37);

        // R6 write transfer with address carry
        program_xfer(16'h00FE, 16'd2);
        wr(3'd0, 8'h12);
        rd(3'd0, d); chk("R4 field write", d[5:3], 3'b010);
        for (int i = 0; i < 2; i++) begin
            strobe(8'h9C + i, re, we, a, rdat, wdat);
            chk("R6 write enables", {re, we}, 2'b01);
            chk("R6 write addr", a, 16'h00FE + i);
            chk("R6 write data", wdat, 8'h9C + i);
        end
        chk("R7 done write", dma_done, 1'b1);
        rd(3'd6, d); chk("R6 carry", d, 8'h01);

        // R5 disallowed codes and relaunch while busy
        program_xfer(16'h0200, 16'd5);
        wr(3'd0, 8'h02);
        chk("R5 code000", dma_busy, 1'b0);
        wr(3'd0, 8'h1A);
        chk("R5 code011", dma_busy, 1'b0);
        rd(3'd3, d); chk("R5 count kept", d, 8'h05);
        wr(3'd0, 8'h0A);
        strobe(8'h00, re, we, a, rdat, wdat);
        wr(3'd0, 8'h12);
        rd(3'd0, d); chk("R5 relaunch ignored", d[5:3], 3'b001);
        rd(3'd5, d); chk("R5 addr unchanged", d, 8'h01);

        // R9 setup writes ignored while busy
        wr(3'd1, 8'h77);
        rd(3'd1, d); chk("R9 start frozen", d, 8'h00);
        wr(3'd3, 8'h09);
        rd(3'd3, d); chk("R9 count frozen", d, 8'h04);

        // R8 abort in the same cycle as a strobe
        strobe(8'h00, re, we, a, rdat, wdat);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 8'h22; dp_strobe = 1'b1;
        #1;
        chk("R8 no access on abort", {mem_re, mem_we}, 2'b00);
        @(negedge clk);
        reg_wr = 1'b0; dp_strobe = 1'b0;
        chk("R8 stopped", dma_busy, 1'b0);
        chk("R8 no done", dma_done, 1'b0);
        rd(3'd3, d); chk("R8 count cleared", d, 8'h00);
        rd(3'd5, d); chk("R8 addr kept", d, 8'h02);
        program_xfer(16'h0300, 16'd4);
        wr(3'd0, 8'h22);
        rd(3'd3, d); chk("R8 idle abort keeps count", d, 8'h04);

        // R6 idle strobe does nothing
        strobe(8'h55, re, we, a, rdat, wdat);
        chk("R6 idle no access", {re, we}, 2'b00);
        rd(3'd3, d); chk("R6 idle count", d, 8'h04);

        // R7 zero-count launch
        program_xfer(16'h0400, 16'd0);
        wr(3'd0, 8'h0A);
        chk("R7 zero done", dma_done, 1'b1);
        chk("R7 zero not busy", dma_busy, 1'b0);
        rd(3'd5, d); chk("R4 zero addr load", d, 8'h00);

        // constrained random transfers
        for (int t = 0; t < 40; t++) begin
            int n, stop_at;
            logic is_wr;
            sa = 16'($urandom);
            n = 1 + int'($urandom % 12);
            cnt = 16'(n);
            is_wr = 1'($urandom);
            stop_at = ($urandom % 3 == 0) ? int'($urandom % n) : n;
            program_xfer(sa, cnt);
            wr(3'd0, is_wr ? 8'h12 : 8'h0A);
            exp_a = sa;
            for (int i = 0; i < n; i++) begin
                if (i == stop_at) begin
                    wr(3'd0, 8'h22);
                    chk("R8 rand stop", {dma_busy, dma_done}, 2'b00);
                    rd(3'd3, d); chk("R8 rand count", d, 8'h00);
                    rd(3'd5, d); chk("R8 rand addr lo", d, exp_a[7:0]);
                    break;
                end
                d = 8'($urandom);
                strobe(d, re, we, a, rdat, wdat);
                chk("R6 rand enables", {re, we}, is_wr ? 2'b01 : 2'b10);
                chk("R6 rand addr", a, exp_a);
                if (is_wr) chk("R6 rand wdata", wdat, d);
                else       chk("R6 rand rdata", rdat, mem_model(exp_a));
                exp_a = exp_a + 16'd1;
                if (i == n - 1) chk("R7 rand done", {dma_done, dma_busy}, 2'b10);
                repeat ($urandom % 3) @(negedge clk);
            end
        end

        summary();
        $finish;
    end
endmodule